// File: doc/BRIEF.md
# Video component input demultiplexer

This block sits between a video source that may deliver component samples in several packings and three aligned output channels: luma (or green), blue-difference (or blue) and red-difference (or red). The format code selects one of four input packings. In the two full-rate packings each of the three 10-bit ports is taken on every clock. In the two half-rate chroma packings the luma and chroma samples share a port, and the block separates them again.

Every pixel leaves with its three components in the same cycle, after a fixed delay that depends only on the packing. A `out_valid` strobe marks each cycle in which a new luma sample reaches the outputs. Each chroma value stays on its output for every luma sample it belongs to.

The multiplex phase of the shared ports restarts on the first clock edge that samples `blank_n` high. The output is a plain stream with a valid strobe and no ready. There is no back-pressure: the consumer must accept a sample in every cycle where `out_valid` is high. `fmt_sel` is static configuration, and it may change only while `rst_n` is low.

Top module: `comp_demux`

## Requirements
- R1: With `fmt_sel` = 00 (GBR, full rate) or 01 (YPbPr, full rate), the values captured from `in_gy`, `in_bpb` and `in_rpr` at one rising edge appear on `out_y`, `out_pb` and `out_pr` respectively, all updated together, 7 rising edges later.
- R2: In both full-rate formats `out_valid` is high in every cycle from the 7th rising edge after reset. In these formats `blank_n` has no effect on outputs or strobe.
- R3: With `fmt_sel` = 10 (two-port half-rate), `in_gy` carries one luma sample per edge. `in_rpr` alternates blue-difference then red-difference. A pixel whose blue-difference and first luma are captured at edge c appears at edge c+8, with the red-difference captured at c+1. The next luma follows at c+9.
- R4: With `fmt_sel` = 11 (one-port half-rate), `in_gy` carries the repeating order blue-difference, luma, red-difference, luma. If the blue-difference is captured at edge c, the pixel holding it, the luma from c+1 and the red-difference from c+2 appears at edge c+9.
- R5: In the one-port format `out_valid` is never high in two consecutive cycles. `out_y` does not change in any cycle where `out_valid` is low.
- R6: A chroma output holds its value until the next chroma sample of that kind reaches the output, so both luma samples of a pair share the same chroma, with no interpolation.
- R7: In both half-rate formats, the first sample captured at an edge that sees `blank_n` high is treated as blue-difference, even if the previous sequence stopped part-way through a group. Each following captured sample advances the phase by one.
- R8: In the half-rate formats, samples captured while `blank_n` is low produce no valid strobe and change no output. `in_bpb` is ignored in both half-rate formats, and `in_rpr` is ignored in the one-port format.
- R9: While `rst_n` is low, all three outputs are zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_n | input | 1 | Blanking, active low; its release restarts the multiplex phase |
| fmt_sel | input | 2 | Input packing: 00 GBR full, 01 YPbPr full, 10 two-port half-rate, 11 one-port half-rate |
| in_gy | input | 10 | Green / luma port, also the shared port in the one-port format |
| in_rpr | input | 10 | Red / red-difference port, carries both chroma kinds in the two-port format |
| in_bpb | input | 10 | Blue / blue-difference port, full-rate formats only |
| out_y | output | 10 | Aligned luma / green output |
| out_pb | output | 10 | Aligned blue-difference / blue output |
| out_pr | output | 10 | Aligned red-difference / red output |
| out_valid | output | 1 | High when a new luma sample is on `out_y` |

## Verification
The bench releases blanking after groups cut short at every phase: after one sample, after a blue-difference and luma pair, and after odd runs in the two-port format. A design that carried the phase across blanking would then swap chroma kinds or put a chroma value on `out_y`. The data is random, and the unused ports are driven with unrelated values throughout. A wrong tap position therefore shows up as a one-cycle skew between components of the same pixel, and a design that leaked `in_bpb` would corrupt a chroma output. The bench also toggles blanking in the full-rate formats, where a design that wrongly gated on it would drop strobes. Chroma outputs are compared in every cycle, so a design that cleared or interpolated chroma between luma samples would fail.

// File: rtl/comp_demux_pkg.sv
package comp_demux_pkg;

  parameter int unsigned PIX_W = 10;

  typedef enum logic [1:0] {
    MODE_GBR444    = 2'b00,
    MODE_YUV444    = 2'b01,
    MODE_YUV422_2P = 2'b10,
    MODE_YUV422_1P = 2'b11
  } fmt_e;

  // One captured input slot: raw ports, multiplex phase and a usable flag
  typedef struct packed {
    logic [PIX_W-1:0] gy;
    logic [PIX_W-1:0] rpr;
    logic [PIX_W-1:0] bpb;
    logic [1:0]       ph;
    logic             live;
  } cap_t;

endpackage

// File: rtl/cdm_capture.sv
module cdm_capture
  import comp_demux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n,
  input  fmt_e             fmt,
  input  logic [PIX_W-1:0] gy,
  input  logic [PIX_W-1:0] rpr,
  input  logic [PIX_W-1:0] bpb,
  output cap_t             cap_q
);

  logic [1:0] run_cnt;
  logic       blank_q;

  // run_cnt counts samples since the last blanked edge; its old value is the phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      blank_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      run_cnt    <= blank_n ? run_cnt + 2'd1 : 2'd0;
      blank_q    <= blank_n;
      cap_q.gy   <= gy;
      cap_q.rpr  <= rpr;
      cap_q.bpb  <= bpb;
      cap_q.ph   <= run_cnt;
      cap_q.live <= fmt[1] ? blank_n : 1'b1;
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_q) |-> (cap_q.ph == 2'd0)); // R7

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && $past(blank_q)) |-> (cap_q.ph == $past(cap_q.ph) + 2'd1)); // R7

endmodule

// File: rtl/cdm_history.sv
module cdm_history
  import comp_demux_pkg::*;
#(
  parameter int unsigned DEPTH = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  cap_t head_i,
  output cap_t tap_o [DEPTH]
);

  cap_t line_q [1:DEPTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 1; j < DEPTH; j++) line_q[j] <= '0;
    end else begin
      line_q[1] <= head_i;
      for (int j = 2; j < DEPTH; j++) line_q[j] <= line_q[j-1];
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_tap
    if (j == 0) begin : g_head
      assign tap_o[j] = head_i;
    end else begin : g_line
      assign tap_o[j] = line_q[j];
    end
  end

endmodule

// File: rtl/cdm_assemble.sv
module cdm_assemble
  import comp_demux_pkg::*;
#(
  parameter int unsigned LAT_444 = 7,
  parameter int unsigned LAT_2P  = 8,
  parameter int unsigned LAT_1P  = 9,
  parameter int unsigned DEPTH   = LAT_1P
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmt_e             fmt,
  input  cap_t             hist_i [DEPTH],
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_pb,
  output logic [PIX_W-1:0] out_pr,
  output logic             out_valid
);

  // Tap j holds the slot captured j+1 edges before the output edge
  localparam int unsigned T444  = LAT_444 - 1;
  localparam int unsigned T2_Y  = LAT_2P - 1;
  localparam int unsigned T2_CB = LAT_2P - 1;
  localparam int unsigned T2_CR = LAT_2P - 2;
  localparam int unsigned T1_CB = LAT_1P - 1;
  localparam int unsigned T1_Y  = LAT_1P - 2;
  localparam int unsigned T1_CR = LAT_1P - 3;

  logic             y_ld, cb_ld, cr_ld;
  logic [PIX_W-1:0] y_nx, cb_nx, cr_nx;

  always_comb begin
    case (fmt)
      MODE_YUV422_2P: begin
        y_ld  = hist_i[T2_Y].live;
        y_nx  = hist_i[T2_Y].gy;
        cb_ld = hist_i[T2_CB].live && !hist_i[T2_CB].ph[0];
        cb_nx = hist_i[T2_CB].rpr;
        cr_ld = hist_i[T2_CR].live && hist_i[T2_CR].ph[0];
        cr_nx = hist_i[T2_CR].rpr;
      end
      MODE_YUV422_1P: begin
        y_ld  = hist_i[T1_Y].live && hist_i[T1_Y].ph[0];
        y_nx  = hist_i[T1_Y].gy;
        cb_ld = hist_i[T1_CB].live && (hist_i[T1_CB].ph == 2'd0);
        cb_nx = hist_i[T1_CB].gy;
        cr_ld = hist_i[T1_CR].live && (hist_i[T1_CR].ph == 2'd2);
        cr_nx = hist_i[T1_CR].gy;
      end
      default: begin
        y_ld  = hist_i[T444].live;
        y_nx  = hist_i[T444].gy;
        cb_ld = hist_i[T444].live;
        cb_nx = hist_i[T444].bpb;
        cr_ld = hist_i[T444].live;
        cr_nx = hist_i[T444].rpr;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= y_ld;
      if (y_ld) out_y <= y_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pb <= '0;
      out_pr <= '0;
    end else begin
      if (cb_ld) out_pb <= cb_nx;
      if (cr_ld) out_pr <= cr_nx;
    end
  end

  AST_LUMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_y)); // R5

  AST_ONEPORT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == MODE_YUV422_1P && $past(fmt) == MODE_YUV422_1P && $past(out_valid))
      |-> !out_valid); // R5

endmodule

// File: rtl/comp_demux.sv
module comp_demux
  import comp_demux_pkg::*;
#(
  parameter int unsigned LAT_444 = 7,
  parameter int unsigned LAT_2P  = 8,
  parameter int unsigned LAT_1P  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blank_n,
  input  logic [1:0]       fmt_sel,
  input  logic [PIX_W-1:0] in_gy,
  input  logic [PIX_W-1:0] in_rpr,
  input  logic [PIX_W-1:0] in_bpb,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_pb,
  output logic [PIX_W-1:0] out_pr,
  output logic             out_valid
);

  localparam int unsigned HIST_DEPTH = LAT_1P;

  fmt_e fmt;
  cap_t cap_q;
  cap_t hist [HIST_DEPTH];

  assign fmt = fmt_e'(fmt_sel);

  cdm_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .blank_n (blank_n),
    .fmt     (fmt),
    .gy      (in_gy),
    .rpr     (in_rpr),
    .bpb     (in_bpb),
    .cap_q   (cap_q)
  );

  cdm_history #(.DEPTH(HIST_DEPTH)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .head_i (cap_q),
    .tap_o  (hist)
  );

  cdm_assemble #(
    .LAT_444 (LAT_444),
    .LAT_2P  (LAT_2P),
    .LAT_1P  (LAT_1P),
    .DEPTH   (HIST_DEPTH)
  ) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .hist_i    (hist),
    .out_y     (out_y),
    .out_pb    (out_pb),
    .out_pr    (out_pr),
    .out_valid (out_valid)
  );

endmodule

// File: tb/comp_demux_bench.sv
module comp_demux_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       blank_n = 1'b0;
  logic [1:0] fmt_sel = 2'b00;
  logic [9:0] in_gy = '0, in_rpr = '0, in_bpb = '0;
  logic [9:0] out_y, out_pb, out_pr;
  logic       out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  comp_demux u_comp_demux (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .fmt_sel(fmt_sel),
    .in_gy(in_gy), .in_rpr(in_rpr), .in_bpb(in_bpb),
    .out_y(out_y), .out_pb(out_pb), .out_pr(out_pr), .out_valid(out_valid)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_tag = "R9";

  // Behavioural model: scheduled output updates keyed by edge number
  int         edge_n;
  int         run;
  logic       pv_y [16], pv_pb [16], pv_pr [16];
  logic [9:0] pd_y [16], pd_pb [16], pd_pr [16];
  logic [9:0] e_y, e_pb, e_pr;
  logic       e_valid;

  task automatic model_clear();
    edge_n = 0; run = 0;
    e_y = '0; e_pb = '0; e_pr = '0; e_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      pv_y[i] = 1'b0; pv_pb[i] = 1'b0; pv_pr[i] = 1'b0;
    end
  endtask

  task automatic sched_y(int at, logic [9:0] v);
    pv_y[at % 16] = 1'b1; pd_y[at % 16] = v;
  endtask
  task automatic sched_pb(int at, logic [9:0] v);
    pv_pb[at % 16] = 1'b1; pd_pb[at % 16] = v;
  endtask
  task automatic sched_pr(int at, logic [9:0] v);
    pv_pr[at % 16] = 1'b1; pd_pr[at % 16] = v;
  endtask

  task automatic model_edge(logic bl, logic [9:0] g, logic [9:0] r, logic [9:0] b);
    int idx;
    int ph;
    edge_n++;
    idx = edge_n % 16;
    e_valid = pv_y[idx];
    if (pv_y[idx])  e_y  = pd_y[idx];
    if (pv_pb[idx]) e_pb = pd_pb[idx];
    if (pv_pr[idx]) e_pr = pd_pr[idx];
    pv_y[idx] = 1'b0; pv_pb[idx] = 1'b0; pv_pr[idx] = 1'b0;
    ph = run % 4;
    if (bl) run++; else run = 0;
    if (!fmt_sel[1]) begin
      sched_y(edge_n + 7, g); sched_pb(edge_n + 7, b); sched_pr(edge_n + 7, r);
    end else if (bl && !fmt_sel[0]) begin
      sched_y(edge_n + 8, g);
      if (ph % 2 == 0) sched_pb(edge_n + 8, r); else sched_pr(edge_n + 7, r);
    end else if (bl) begin
      if (ph == 0) sched_pb(edge_n + 9, g);
      else if (ph == 2) sched_pr(edge_n + 7, g);
      else sched_y(edge_n + 8, g);
    end
  endtask

  task automatic chk(string what, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h (t=%0t)", cur_tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("out_valid", {9'd0, out_valid}, {9'd0, e_valid});
    chk("out_y", out_y, e_y);
    chk("out_pb", out_pb, e_pb);
    chk("out_pr", out_pr, e_pr);
  endtask

  // Called at a falling edge: drive, let one rising edge pass, model and compare
  task automatic cycle(logic bl);
    logic [9:0] g, r, b;
    g = 10'($urandom); r = 10'($urandom); b = 10'($urandom);
    blank_n = bl; in_gy = g; in_rpr = r; in_bpb = b;
    @(negedge clk);
    model_edge(bl, g, r, b);
    compare_all();
  endtask

  task automatic run_n(logic bl, int n);
    for (int i = 0; i < n; i++) cycle(bl);
  endtask

  task automatic restart(logic [1:0] f);
    rst_n = 1'b0;
    fmt_sel = f;
    blank_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_clear();
    cur_tag = "R9";
    compare_all();
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    model_clear();
    @(negedge clk);

    // Full-rate GBR: straight routing, 7-edge latency, blank has no effect
    restart(2'b00);
    cur_tag = "R1"; run_n(1'b1, 30);
    cur_tag = "R2"; run_n(1'b0, 4);
    run_n(1'b1, 20);

    // Full-rate YPbPr
    restart(2'b01);
    cur_tag = "R1"; run_n(1'b1, 25);
    cur_tag = "R2"; run_n(1'b0, 3);
    run_n(1'b1, 12);

    // Two-port half-rate: phase restarts, chroma hold, ignored ports
    restart(2'b10);
    cur_tag = "R8"; run_n(1'b0, 5);
    cur_tag = "R3"; run_n(1'b1, 24);
    cur_tag = "R7"; run_n(1'b0, 3);
    run_n(1'b1, 1);
    run_n(1'b0, 2);
    run_n(1'b1, 3);
    run_n(1'b0, 1);
    cur_tag = "R6"; run_n(1'b1, 21);
    cur_tag = "R8"; run_n(1'b0, 12);

    // One-port half-rate: cadence, truncated groups, chroma hold
    restart(2'b11);
    cur_tag = "R8"; run_n(1'b0, 6);
    cur_tag = "R4"; run_n(1'b1, 30);
    cur_tag = "R7"; run_n(1'b0, 2);
    run_n(1'b1, 2);
    run_n(1'b0, 1);
    run_n(1'b1, 3);
    run_n(1'b0, 3);
    run_n(1'b1, 1);
    run_n(1'b0, 2);
    cur_tag = "R5"; run_n(1'b1, 40);
    cur_tag = "R6"; run_n(1'b0, 12);

    summary();
    $finish;
  end

endmodule